// File: doc/BRIEF.md
# Hashed Page Table Entry Encoder

This unit forms the two 64-bit words of a hashed page table entry from a virtual page number and a physical address. It also converts existing entries between the legacy word layout and the newer one, and it answers whether a probe word matches a stored first word. A small register file, programmed through a write port, describes each page size. Each entry holds a shift amount, an AVPN mask, and one large-page encoding byte for every actual page size that can pair with it as the base size.

Requests arrive on a valid/ready handshake with a two-bit operation code. The result is registered and appears one clock after the request is accepted. While the consumer holds off, the result stays in place and no new request is taken.

Top module: `pte_codec`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid is 0, req_ready is 1, and every register file field (shift, mask, encoding byte) is zero.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. Its result is on the rsp_* outputs with rsp_valid=1 after that edge. req_ready is 0 while rsp_valid=1 and rsp_ready=0, and during that time the result holds unchanged.
- R3: Encode (op 0, w0 = VPN, w1 = physical address). Word 0 carries ((VPN >> 11) AND NOT mask[base]) shifted left by 7. Its bits 6:5, 3 and 1:0 are zero.
- R4: Encode places the segment code at word 0 bits 63:62 (0 = 256 MB, 1 = 1 TB), ORed over the AVPN field. It sets word 0 bit 2 exactly when the actual size index is not 0. Index 0 denotes the 4 KB page.
- R5: Encode with actual index 0 gives word 1 = address AND 0x0FFFFFFFFFFFF000.
- R6: Encode with a nonzero actual index gives word 1 = (address with its low shift[actual] bits cleared) OR (enc[base][actual] << 12).
- R7: Legacy-to-new (op 1, w0/w1 = legacy words). The new word 0 is w0 with bits 63:52 cleared. The new word 1 is w1 with bits 59:58 replaced by w0 bits 63:62.
- R8: New-to-legacy (op 2, w0/w1 = new words). The legacy word 0 is w0 bits 51:0, with w1 bits 59:58 placed at bits 63:62. The legacy word 1 is w1 with bits 59:58 cleared.
- R9: Compare (op 3, w0 = probe, w1 = stored word) sets rsp_match when the two words agree in bits 63:7, whatever bits 6:0 hold. Both result words are zero. rsp_match is 0 for every other operation.
- R10: An encode with segment code 2 or 3 sets rsp_err and gives zero for both words. No other operation sets rsp_err.
- R11: A table write with cfg_we=1 takes effect for requests accepted on later edges. cfg_field 0 loads shift[cfg_idx] from cfg_data[5:0]. Field 1 loads mask[cfg_idx] from cfg_data. Field 2 loads enc[cfg_idx][cfg_sub] from cfg_data[7:0]. Field 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_field | input | 2 | Field select: 0 shift, 1 mask, 2 encoding byte, 3 none |
| cfg_idx | input | 4 | Page size entry written |
| cfg_sub | input | 4 | Actual size slot for an encoding byte write |
| cfg_data | input | 64 | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 encode, 1 legacy-to-new, 2 new-to-legacy, 3 compare |
| req_w0 | input | 64 | VPN / first word / probe |
| req_w1 | input | 64 | Physical address / second word / stored word |
| req_base | input | 4 | Base page size index |
| req_act | input | 4 | Actual page size index |
| req_seg | input | 2 | Segment size code |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_d0 | output | 64 | Result word 0 |
| rsp_d1 | output | 64 | Result word 1 |
| rsp_match | output | 1 | Compare outcome |
| rsp_err | output | 1 | Reserved segment code seen |

## Verification
The bench sweeps all 256 pairs of base and actual index against a fully programmed table. A design that read the encoding byte with the indices swapped, or took the alignment shift from the base size, gives wrong second words on the off-diagonal pairs. The large bit is checked separately, so a design that keyed it off the base size fails on the pairs where base and actual differ.

Compare is driven with differences in each of bits 0 to 7 and in bit 63. A mask one bit too wide or too narrow turns a match into a miss, or a miss into a match. Both conversions are checked on many patterns, so a segment field moved to the wrong pair of bits is caught.

Reserved segment codes must give zero words with the error flag set. A stall with a second request waiting must keep the first result in place, and must then pass the second request through.

// File: rtl/pte_pkg.sv
// Shared constants and types for the page table entry encoder.
// Assumes 64-bit entry words; field positions are fixed by the entry format.
package pte_pkg;
    localparam int WORD_W     = 64;
    localparam int SEG_OLD_LO = 62;   // segment code, legacy word 0
    localparam int SEG_NEW_LO = 58;   // segment code, new word 1
    localparam int AVPN_LSB   = 7;
    localparam int VPN_DROP   = 11;
    localparam int RPN_LSB    = 12;
    localparam int LARGE_BIT  = 2;
    localparam int COMMON_W   = 52;
    localparam int CMP_IGNORE = 7;

    localparam logic [WORD_W-1:0] RPN_SMALL_MASK = 64'h0FFF_FFFF_FFFF_F000;
    localparam logic [WORD_W-1:0] COMMON_MASK    = (64'd1 << COMMON_W) - 64'd1;
    localparam logic [WORD_W-1:0] SEG_NEW_MASK   = 64'd3 << SEG_NEW_LO;
    localparam logic [WORD_W-1:0] CMP_MASK       = ~((64'd1 << CMP_IGNORE) - 64'd1);

    typedef enum logic [1:0] {
        OP_ENCODE = 2'd0,
        OP_TO_NEW = 2'd1,
        OP_TO_OLD = 2'd2,
        OP_MATCH  = 2'd3
    } pte_op_e;

    typedef enum logic [1:0] {
        FLD_SHIFT = 2'd0,
        FLD_MASK  = 2'd1,
        FLD_ENC   = 2'd2,
        FLD_NONE  = 2'd3
    } cfg_fld_e;

    typedef struct packed {
        logic [WORD_W-1:0] d0;
        logic [WORD_W-1:0] d1;
        logic              match;
        logic              err;
    } pte_rsp_t;
endpackage

// File: rtl/pte_size_table.sv
// Per-page-size register file: a shift and an AVPN mask per entry, plus one
// encoding byte per (base, actual) pair. Single write port, combinational reads.
// Assumes the indices presented on the read side are already stable.
module pte_size_table
    import pte_pkg::*;
#(
    parameter int NUM_SIZES = 16,
    parameter int SHIFT_W   = 6,
    parameter int ENC_W     = 8,
    localparam int IDX_W    = $clog2(NUM_SIZES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  wr_sub,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_base,
    input  logic [IDX_W-1:0]  rd_act,
    output logic [WORD_W-1:0] base_mask,
    output logic [SHIFT_W-1:0] act_shift,
    output logic [ENC_W-1:0]  pair_enc
);
    logic [SHIFT_W-1:0] shift_q [NUM_SIZES];
    logic [WORD_W-1:0]  mask_q  [NUM_SIZES];
    logic [ENC_W-1:0]   enc_q   [NUM_SIZES][NUM_SIZES];

    // Clear on reset, otherwise load the selected field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SIZES; i++) begin
                shift_q[i] <= '0;
                mask_q[i]  <= '0;
                for (int j = 0; j < NUM_SIZES; j++) enc_q[i][j] <= '0;
            end
        end else if (wr_en) begin
            case (cfg_fld_e'(wr_field))
                FLD_SHIFT: shift_q[wr_idx]        <= wr_data[SHIFT_W-1:0];
                FLD_MASK:  mask_q[wr_idx]         <= wr_data;
                FLD_ENC:   enc_q[wr_idx][wr_sub]  <= wr_data[ENC_W-1:0];
                default:   ;
            endcase
        end
    end

    // Read ports for the current request.
    always_comb begin
        base_mask = mask_q[rd_base];
        act_shift = shift_q[rd_act];
        pair_enc  = enc_q[rd_base][rd_act];
    end
endmodule

// File: rtl/pte_encode.sv
// Builds both entry words (legacy layout) from a VPN and a physical address.
// Assumes the table values for the request's sizes are already on its inputs.
module pte_encode
    import pte_pkg::*;
#(
    parameter int SHIFT_W = 6,
    parameter int ENC_W   = 8
) (
    input  logic [WORD_W-1:0]  vpn,
    input  logic [WORD_W-1:0]  pa,
    input  logic [WORD_W-1:0]  base_mask,
    input  logic [SHIFT_W-1:0] act_shift,
    input  logic [ENC_W-1:0]   pair_enc,
    input  logic               act_large,
    input  logic [1:0]         seg,
    output logic [WORD_W-1:0]  d0,
    output logic [WORD_W-1:0]  d1,
    output logic               err
);
    logic [WORD_W-1:0] avpn;
    logic [WORD_W-1:0] align;

    // Form the words; a reserved segment code zeroes them and flags an error.
    always_comb begin
        err   = seg[1];
        avpn  = ((vpn >> VPN_DROP) & ~base_mask) << AVPN_LSB;
        align = ~((64'd1 << act_shift) - 64'd1);
        d0    = avpn | {seg, {SEG_OLD_LO{1'b0}}}
                     | ({{(WORD_W-1){1'b0}}, act_large} << LARGE_BIT);
        if (act_large)
            d1 = (pa & align) | ({{(WORD_W-ENC_W){1'b0}}, pair_enc} << RPN_LSB);
        else
            d1 = pa & RPN_SMALL_MASK;
        if (err) begin
            d0 = '0;
            d1 = '0;
        end
    end
endmodule

// File: rtl/pte_convert.sv
// Moves the segment code between the two entry layouts and compares a probe
// with a stored first word. Outputs are zero for operations it does not own.
module pte_convert
    import pte_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    output logic [WORD_W-1:0] d0,
    output logic [WORD_W-1:0] d1,
    output logic              match
);
    // Select the conversion or the comparison by operation.
    always_comb begin
        d0    = '0;
        d1    = '0;
        match = 1'b0;
        case (pte_op_e'(op))
            OP_TO_NEW: begin
                d0 = w0 & COMMON_MASK;
                d1 = (w1 & ~SEG_NEW_MASK)
                   | ({{(WORD_W-2){1'b0}}, w0[WORD_W-1:SEG_OLD_LO]} << SEG_NEW_LO);
            end
            OP_TO_OLD: begin
                d0 = (w0 & COMMON_MASK)
                   | ({{(WORD_W-2){1'b0}}, w1[SEG_NEW_LO+1:SEG_NEW_LO]} << SEG_OLD_LO);
                d1 = w1 & ~SEG_NEW_MASK;
            end
            OP_MATCH: match = ((w0 ^ w1) & CMP_MASK) == '0;
            default: ;
        endcase
    end
endmodule

// File: rtl/pte_codec.sv
// Top: request handshake, table, encoder, converter and one output register.
// Assumes the consumer may stall; a held result blocks new requests.
module pte_codec
    import pte_pkg::*;
#(
    parameter int NUM_SIZES = 16,
    parameter int SHIFT_W   = 6,
    parameter int ENC_W     = 8,
    localparam int IDX_W    = $clog2(NUM_SIZES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_field,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [IDX_W-1:0]  cfg_sub,
    input  logic [63:0]       cfg_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [63:0]       req_w0,
    input  logic [63:0]       req_w1,
    input  logic [IDX_W-1:0]  req_base,
    input  logic [IDX_W-1:0]  req_act,
    input  logic [1:0]        req_seg,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_d0,
    output logic [63:0]       rsp_d1,
    output logic              rsp_match,
    output logic              rsp_err
);
    logic [WORD_W-1:0]  tb_mask;
    logic [SHIFT_W-1:0] tb_shift;
    logic [ENC_W-1:0]   tb_enc;
    logic [WORD_W-1:0]  en_d0, en_d1, cv_d0, cv_d1;
    logic               en_err, cv_match;
    pte_rsp_t           nxt, rsp_q;
    logic               valid_q;

    pte_size_table #(.NUM_SIZES(NUM_SIZES), .SHIFT_W(SHIFT_W), .ENC_W(ENC_W)) u_tab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_field(cfg_field), .wr_idx(cfg_idx), .wr_sub(cfg_sub),
        .wr_data(cfg_data), .rd_base(req_base), .rd_act(req_act),
        .base_mask(tb_mask), .act_shift(tb_shift), .pair_enc(tb_enc)
    );

    pte_encode #(.SHIFT_W(SHIFT_W), .ENC_W(ENC_W)) u_enc (
        .vpn(req_w0), .pa(req_w1), .base_mask(tb_mask), .act_shift(tb_shift),
        .pair_enc(tb_enc), .act_large(req_act != '0), .seg(req_seg),
        .d0(en_d0), .d1(en_d1), .err(en_err)
    );

    pte_convert u_cnv (
        .op(req_op), .w0(req_w0), .w1(req_w1),
        .d0(cv_d0), .d1(cv_d1), .match(cv_match)
    );

    // Take a request when the output slot is empty or being drained.
    assign req_ready = !valid_q || rsp_ready;

    // Choose the result of the requested operation.
    always_comb begin
        nxt = '0;
        if (pte_op_e'(req_op) == OP_ENCODE) begin
            nxt.d0  = en_d0;
            nxt.d1  = en_d1;
            nxt.err = en_err;
        end else begin
            nxt.d0    = cv_d0;
            nxt.d1    = cv_d1;
            nxt.match = cv_match;
        end
    end

    // Output register with hold under back-pressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else if (req_ready) begin
            valid_q <= req_valid;
            if (req_valid) rsp_q <= nxt;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_d0    = rsp_q.d0;
    assign rsp_d1    = rsp_q.d1;
    assign rsp_match = rsp_q.match;
    assign rsp_err   = rsp_q.err;
endmodule

// File: rtl/pte_codec_chk.sv
// Protocol and result-shape properties for pte_codec, attached by bind.
module pte_codec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_op,
    input logic [1:0]  req_seg,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_d0,
    input logic [63:0] rsp_d1,
    input logic        rsp_match,
    input logic        rsp_err
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_d0) && $stable(rsp_d1)
                                    && $stable(rsp_err) && $stable(rsp_match));

    assert_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_d0 == 64'd0 && rsp_d1 == 64'd0);

    assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_op == 2'd0 && req_seg[1] |=> rsp_err);

    assert_err_only_enc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_op != 2'd0 |=> !rsp_err);

    assert_match_words_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_match |-> rsp_d0 == 64'd0 && rsp_d1 == 64'd0);
endmodule

bind pte_codec pte_codec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_seg(req_seg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_d0(rsp_d0), .rsp_d1(rsp_d1), .rsp_match(rsp_match), .rsp_err(rsp_err)
);

// File: tb/sim_pte_codec.sv
module sim_pte_codec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_field = '0;
    logic [3:0] cfg_idx = '0, cfg_sub = '0;
    logic [63:0] cfg_data = '0;
    logic req_valid = 1'b0, rsp_ready = 1'b1;
    logic [1:0] req_op = '0, req_seg = '0;
    logic [63:0] req_w0 = '0, req_w1 = '0;
    logic [3:0] req_base = '0, req_act = '0;
    logic req_ready, rsp_valid, rsp_match, rsp_err;
    logic [63:0] rsp_d0, rsp_d1;

    int n_chk = 0, n_fail = 0;
    logic [5:0]  m_sh [16];
    logic [63:0] m_mk [16];
    logic [7:0]  m_en [16][16];
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    pte_codec u0 (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [63:0] nxt_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    task automatic cfg_wr(input logic [1:0] f, input int i, input int s, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_field = f; cfg_idx = 4'(i); cfg_sub = 4'(s); cfg_data = d;
    endtask

    task automatic do_req(input logic [1:0] op, input logic [63:0] w0, input logic [63:0] w1,
                          input int b, input int a, input logic [1:0] sg);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_w0 = w0; req_w1 = w1;
        req_base = 4'(b); req_act = 4'(a); req_seg = sg;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic exp_enc(input int b, input int a, input logic [1:0] sg,
                           input logic [63:0] vpn, input logic [63:0] pa,
                           output logic [63:0] e0, output logic [63:0] e1);
        e0 = (((vpn >> 11) & ~m_mk[b]) << 7) | ({62'd0, sg} << 62) | ((a != 0) ? 64'd4 : 64'd0);
        if (a == 0) e1 = pa & 64'h0FFF_FFFF_FFFF_F000;
        else e1 = (pa & ~((64'd1 << m_sh[a]) - 64'd1)) | ({56'd0, m_en[b][a]} << 12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [63:0] v, p, e0, e1, a0, b0, b1;
        for (int i = 0; i < 16; i++) begin
            m_sh[i] = '0; m_mk[i] = '0;
            for (int j = 0; j < 16; j++) m_en[i][j] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 req_ready", {63'd0, req_ready}, 64'd1);

        // R1: cleared table, large actual size
        v = nxt_rand(); p = nxt_rand();
        do_req(2'd0, v, p, 1, 1, 2'd0);
        exp_enc(1, 1, 2'd0, v, p, e0, e1);
        check("R1 d0 empty table", rsp_d0, e0);
        check("R1 d1 empty table", rsp_d1, e1);

        // R11: program the table
        for (int i = 0; i < 16; i++) begin
            m_sh[i] = 6'(12 + i);
            m_mk[i] = (64'd1 << i) - 64'd1;
            cfg_wr(2'd0, i, 0, {58'h3FF_FFFF_FFFF_FFFF, m_sh[i]});
            cfg_wr(2'd1, i, 0, m_mk[i]);
            for (int j = 0; j < 16; j++) begin
                m_en[i][j] = 8'((i * 16 + j) ^ 8'h5A);
                cfg_wr(2'd2, i, j, {56'hFFFF_FFFF_FFFF_FF, m_en[i][j]});
            end
        end
        // R11: field 3 must change nothing
        cfg_wr(2'd3, 5, 5, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        cfg_we = 1'b0;

        // R3 R4 R5 R6: sweep every base/actual pair
        for (int b = 0; b < 16; b++) begin
            for (int a = 0; a < 16; a++) begin
                logic [1:0] sg;
                sg = 2'((a + b) % 2);
                v = nxt_rand(); p = nxt_rand();
                do_req(2'd0, v, p, b, a, sg);
                exp_enc(b, a, sg, v, p, e0, e1);
                check("R3 R4 R11 encode d0", rsp_d0, e0);
                check(a == 0 ? "R5 encode d1" : "R6 encode d1", rsp_d1, e1);
                check("R10 no err", {63'd0, rsp_err}, 64'd0);
            end
        end
        check("R2 rsp_valid after accept", {63'd0, rsp_valid}, 64'd1);

        // R10: reserved segment codes
        for (int s = 2; s < 4; s++) begin
            do_req(2'd0, nxt_rand(), nxt_rand(), 3, 2, 2'(s));
            check("R10 err", {63'd0, rsp_err}, 64'd1);
            check("R10 d0 zero", rsp_d0, 64'd0);
            check("R10 d1 zero", rsp_d1, 64'd0);
        end

        // R7 R8: conversions
        for (int k = 0; k < 24; k++) begin
            v = nxt_rand(); p = nxt_rand();
            do_req(2'd1, v, p, 0, 0, 2'd2);
            check("R7 new d0", rsp_d0, {12'd0, v[51:0]});
            check("R7 new d1", rsp_d1, {p[63:60], v[63:62], p[57:0]});
            check("R10 conv no err", {63'd0, rsp_err}, 64'd0);
            do_req(2'd2, v, p, 0, 0, 2'd3);
            check("R8 old d0", rsp_d0, {p[59:58], 10'd0, v[51:0]});
            check("R8 old d1", rsp_d1, {p[63:60], 2'd0, p[57:0]});
            check("R9 no match on convert", {63'd0, rsp_match}, 64'd0);
        end

        // R9: compare ignoring bits 6:0
        v = nxt_rand();
        do_req(2'd3, v, v, 0, 0, 2'd0);
        check("R9 equal", {63'd0, rsp_match}, 64'd1);
        check("R9 words zero", rsp_d0 | rsp_d1, 64'd0);
        for (int k = 0; k < 8; k++) begin
            do_req(2'd3, v, v ^ (64'd1 << k), 0, 0, 2'd0);
            check(k < 7 ? "R9 low bit ignored" : "R9 bit 7 counts", {63'd0, rsp_match},
                  k < 7 ? 64'd1 : 64'd0);
        end
        do_req(2'd3, v, v ^ 64'h8000_0000_0000_007F, 0, 0, 2'd0);
        check("R9 bit 63 counts", {63'd0, rsp_match}, 64'd0);

        // R2: stall holds result and blocks the next request
        a0 = nxt_rand(); b0 = nxt_rand(); b1 = nxt_rand();
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_op = 2'd1; req_w0 = a0; req_w1 = 64'd0;
        @(negedge clk);
        check("R2 valid during stall", {63'd0, rsp_valid}, 64'd1);
        check("R2 ready low in stall", {63'd0, req_ready}, 64'd0);
        req_op = 2'd2; req_w0 = b0; req_w1 = b1;
        @(negedge clk);
        check("R2 held result", rsp_d0, {12'd0, a0[51:0]});
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 next result", rsp_d0, {b1[59:58], 10'd0, b0[51:0]});
        check("R2 next result d1", rsp_d1, {b1[63:60], 2'd0, b1[57:0]});
        @(negedge clk);
        check("R2 drained", {63'd0, rsp_valid}, 64'd0);

        finish_up();
    end
endmodule